// File: doc/BRIEF.md
# Serial Programming Command Slave

This block is the device side of a four-byte serial programming link. An external programmer drives a serial clock and a data line into the chip. The block samples both into the system clock domain, gathers each 32-bit instruction most significant bit first, and decodes it. It shifts a reply byte back out while the next byte comes in. The reply is normally the byte received just before. For read commands, the fourth reply byte carries the requested byte from program memory, data memory or the identification bytes.

The program array is word addressed and is stored as a low byte lane and a high byte lane. The data array is byte addressed. Both arrays are behavioural and sit inside the block. They keep their contents across a reset of the controller.

All commands except the enable command are ignored until a valid enable frame has been received. The link never re-aligns itself: every frame is exactly 32 SCK rising edges long. Writes and the full erase are self-timed. While one is in progress, the `busy` output is high, and further write or erase frames are dropped.

The controller has four states:
- LOCKED is entered on reset. It leaves only to IDLE, on an enable frame.
- IDLE goes to ERASE on an erase frame, and to HOLD on a program-write or data-write frame.
- ERASE walks one address per clock through both arrays. After the last address it goes to HOLD.
- HOLD counts the write delay down, then returns to IDLE.

Top module: `spi_prog_slave`

## Requirements
- R1: Each instruction is exactly 32 bits, sent MSB first. A data bit is taken on each rising SCK edge. After every 32 rising edges a new frame starts, whatever the content.
- R2: MISO changes only after a falling SCK edge. During bytes 2 to 4 of a frame, MISO returns the previous byte of the same frame, so the enable byte 0x53 comes back during byte 3. During byte 1, MISO returns the last byte of the previous frame, or 0x00 after reset.
- R3: After reset the block is locked and `prog_enabled` is low. Only the frame 0xAC, 0x53, x, x unlocks it. While locked, reads return the echo, and writes and erase change no memory and raise no busy.
- R4: Program write uses byte 1 = 0x40, or 0x48 for the high byte, and byte 4 is the data. Program read uses 0x20 or 0x28, and the data comes back in byte 4. H is bit 3 of byte 1. The word address is the low PROG_AW bits of {byte 2, byte 3}.
- R5: Data write uses byte 1 = 0xC0, and byte 4 is the data. Data read uses 0xA0, and the data comes back in byte 4. The address is the low DATA_AW bits of byte 3, and upper bits are ignored.
- R6: Identification read uses byte 1 = 0x30, with the index in bits 1:0 of byte 3. Index 0 returns 0x1E, 1 returns 0x90, 2 returns DEV_CODE and 3 returns 0xFF.
- R7: Erase uses byte 1 = 0xAC with byte 2 bits 7:5 = 100. It sets every program byte and every data byte to 0xFF.
- R8: After an accepted write, `busy` is high for exactly WR_DELAY consecutive clocks. After an erase, it is high for 2^max(PROG_AW,DATA_AW) + WR_DELAY clocks.
- R9: A write or erase frame that ends while `busy` is high is dropped. It neither changes memory nor lengthens the busy period.
- R10: A frame with an unrecognised first byte has no effect and returns the plain echo.
- R11: Reset returns the controller to LOCKED and clears the reply byte to 0x00. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the controller |
| sck | input | 1 | Serial clock from the programmer; high and low phases each at least two clk periods |
| mosi | input | 1 | Serial command data in |
| miso | output | 1 | Serial reply data out |
| busy | output | 1 | High while a self-timed write or erase runs |
| prog_enabled | output | 1 | High once a valid enable frame has been accepted |

## Verification
A bit counter that slips shows up within one byte: every later reply byte then comes back rotated against the echo the programmer expects. A controller stuck in the wrong state is visible at the ports one frame later, either as a reply that should be echo but carries memory data, or the reverse, or through `prog_enabled`. A wrong delay count or a lost self-timed write shows up at the falling edge of `busy`, as a run of the wrong length. A bad address or lane selection shows up on the next read-back of the affected location.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED,
        ST_IDLE,
        ST_ERASE,
        ST_HOLD
    } sp_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ENABLE,
        OP_ERASE,
        OP_RD_PROG,
        OP_WR_PROG,
        OP_RD_DATA,
        OP_WR_DATA,
        OP_RD_SIG
    } sp_op_e;

    localparam logic [7:0] SIG_VENDOR = 8'h1E;
    localparam logic [7:0] SIG_SIZE   = 8'h90;
    localparam logic [7:0] BLANK      = 8'hFF;

    // Classify a command from its first two bytes.
    function automatic sp_op_e sp_decode(input logic [7:0] b0, input logic [7:0] b1);
        sp_op_e op;
        op = OP_NONE;
        if (b0 == 8'hAC && b1 == 8'h53)
            op = OP_ENABLE;
        else if (b0 == 8'hAC && b1[7:5] == 3'b100)
            op = OP_ERASE;
        else if (b0[7:4] == 4'h2 && b0[2:0] == 3'b000)
            op = OP_RD_PROG;
        else if (b0[7:4] == 4'h4 && b0[2:0] == 3'b000)
            op = OP_WR_PROG;
        else if (b0 == 8'hA0)
            op = OP_RD_DATA;
        else if (b0 == 8'hC0)
            op = OP_WR_DATA;
        else if (b0 == 8'h30)
            op = OP_RD_SIG;
        return op;
    endfunction

endpackage

// File: rtl/sp_shift.sv
module sp_shift #(
    parameter int FRAME_BITS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sck,
    input  logic                  mosi,
    input  logic                  rd_sel,
    input  logic [7:0]            rd_byte,
    output logic [FRAME_BITS-1:0] frame,
    output logic                  frame_done,
    output logic                  miso
);
    localparam int CW       = $clog2(FRAME_BITS);
    localparam int RD_POINT = FRAME_BITS - 8;

    logic [2:0]    sck_q;
    logic [1:0]    mosi_q;
    logic [CW-1:0] bit_cnt;
    logic [7:0]    tx;
    logic          load_pend;
    logic          sck_rise;
    logic          sck_fall;

    // Two-stage synchronisers plus one extra stage for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= '0;
            mosi_q <= '0;
        end else begin
            sck_q  <= {sck_q[1:0], sck};
            mosi_q <= {mosi_q[0], mosi};
        end
    end

    assign sck_rise = sck_q[1] & ~sck_q[2];
    assign sck_fall = ~sck_q[1] & sck_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame      <= '0;
            bit_cnt    <= '0;
            frame_done <= 1'b0;
            load_pend  <= 1'b0;
            tx         <= '0;
        end else begin
            frame_done <= 1'b0;
            if (sck_rise) begin
                frame   <= {frame[FRAME_BITS-2:0], mosi_q[1]};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt[2:0] == 3'd7)
                    load_pend <= 1'b1;
                if (bit_cnt == CW'(FRAME_BITS - 1))
                    frame_done <= 1'b1;
            end
            if (sck_fall) begin
                if (load_pend) begin
                    load_pend <= 1'b0;
                    tx <= (rd_sel && bit_cnt == CW'(RD_POINT)) ? rd_byte : frame[7:0];
                end else begin
                    tx <= {tx[6:0], 1'b0};
                end
            end
        end
    end

    assign miso = tx[7];

endmodule

// File: rtl/sp_ctrl.sv
module sp_ctrl
    import sp_pkg::*;
#(
    parameter int PROG_AW  = 9,
    parameter int DATA_AW  = 6,
    parameter int WR_DELAY = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_done,
    input  sp_op_e               frame_op,
    output logic                 enabled,
    output logic                 busy,
    output logic                 prog_we,
    output logic                 data_we,
    output logic                 erase_we,
    output logic [((PROG_AW > DATA_AW) ? PROG_AW : DATA_AW)-1:0] erase_addr
);
    localparam int EAW = (PROG_AW > DATA_AW) ? PROG_AW : DATA_AW;
    localparam int DW  = $clog2(WR_DELAY + 1);

    sp_state_e     state;
    sp_state_e     state_nx;
    logic [EAW-1:0] sweep;
    logic [DW-1:0]  hold_cnt;
    logic           sweep_last;
    logic           hold_last;
    logic           write_frame;

    assign sweep_last  = &sweep;
    assign hold_last   = (hold_cnt == '0);
    assign write_frame = frame_done && (frame_op == OP_WR_PROG || frame_op == OP_WR_DATA);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_LOCKED;
        else
            state <= state_nx;
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOCKED: begin
                if (frame_done && frame_op == OP_ENABLE)
                    state_nx = ST_IDLE;
            end
            ST_IDLE: begin
                if (frame_done && frame_op == OP_ERASE)
                    state_nx = ST_ERASE;
                else if (write_frame)
                    state_nx = ST_HOLD;
            end
            ST_ERASE: begin
                if (sweep_last)
                    state_nx = ST_HOLD;
            end
            ST_HOLD: begin
                if (hold_last)
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_LOCKED;
        endcase
    end

    // Sweep address and write-delay counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sweep    <= '0;
            hold_cnt <= '0;
        end else begin
            if (state == ST_ERASE)
                sweep <= sweep + 1'b1;
            if (state_nx == ST_HOLD && state != ST_HOLD)
                hold_cnt <= DW'(WR_DELAY - 1);
            else if (state == ST_HOLD && !hold_last)
                hold_cnt <= hold_cnt - 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        enabled    = (state != ST_LOCKED);
        busy       = (state == ST_ERASE) || (state == ST_HOLD);
        prog_we    = (state == ST_IDLE) && frame_done && (frame_op == OP_WR_PROG);
        data_we    = (state == ST_IDLE) && frame_done && (frame_op == OP_WR_DATA);
        erase_we   = (state == ST_ERASE);
        erase_addr = sweep;
    end

endmodule

// File: rtl/sp_mem.sv
module sp_mem #(
    parameter int PROG_AW = 9,
    parameter int DATA_AW = 6
) (
    input  logic               clk,
    input  logic               prog_we,
    input  logic               prog_hi,
    input  logic [PROG_AW-1:0] prog_waddr,
    input  logic [7:0]         prog_wdata,
    input  logic               data_we,
    input  logic [DATA_AW-1:0] data_waddr,
    input  logic [7:0]         data_wdata,
    input  logic               erase_we,
    input  logic [((PROG_AW > DATA_AW) ? PROG_AW : DATA_AW)-1:0] erase_addr,
    input  logic [PROG_AW-1:0] prog_raddr,
    input  logic               prog_rhi,
    output logic [7:0]         prog_rdata,
    input  logic [DATA_AW-1:0] data_raddr,
    output logic [7:0]         data_rdata
);
    localparam int PROG_WORDS = 1 << PROG_AW;
    localparam int DATA_BYTES = 1 << DATA_AW;

    logic [1:0][7:0] lane_rd;

    // One storage lane per byte of the program word.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam logic LANE_HI = (g == 1);
        logic [7:0] mem [PROG_WORDS];

        always_ff @(posedge clk) begin
            if (erase_we)
                mem[erase_addr[PROG_AW-1:0]] <= sp_pkg::BLANK;
            else if (prog_we && prog_hi == LANE_HI)
                mem[prog_waddr] <= prog_wdata;
        end

        assign lane_rd[g] = mem[prog_raddr];
    end

    logic [7:0] dmem [DATA_BYTES];

    always_ff @(posedge clk) begin
        if (erase_we)
            dmem[erase_addr[DATA_AW-1:0]] <= sp_pkg::BLANK;
        else if (data_we)
            dmem[data_waddr] <= data_wdata;
    end

    assign prog_rdata = lane_rd[prog_rhi];
    assign data_rdata = dmem[data_raddr];

endmodule

// File: rtl/spi_prog_slave.sv
module spi_prog_slave
    import sp_pkg::*;
#(
    parameter int         PROG_AW  = 9,
    parameter int         DATA_AW  = 6,
    parameter int         WR_DELAY = 64,
    parameter logic [7:0] DEV_CODE = 8'h05
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic busy,
    output logic prog_enabled
);
    localparam int FRAME_BITS = 32;
    localparam int EAW        = (PROG_AW > DATA_AW) ? PROG_AW : DATA_AW;

    logic [FRAME_BITS-1:0] frame;
    logic                  frame_done;
    logic                  rd_sel;
    logic [7:0]            rd_byte;
    sp_op_e                done_op;
    sp_op_e                rd_op;
    logic                  prog_we;
    logic                  data_we;
    logic                  erase_we;
    logic [EAW-1:0]        erase_addr;
    logic [7:0]            prog_rdata;
    logic [7:0]            data_rdata;

    // Completed frame: bytes in [31:24] .. [7:0].
    // At the read point only three bytes are in, held in [23:0].
    assign done_op = sp_decode(frame[31:24], frame[23:16]);
    assign rd_op   = sp_decode(frame[23:16], frame[15:8]);

    sp_shift #(
        .FRAME_BITS (FRAME_BITS)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck        (sck),
        .mosi       (mosi),
        .rd_sel     (rd_sel),
        .rd_byte    (rd_byte),
        .frame      (frame),
        .frame_done (frame_done),
        .miso       (miso)
    );

    sp_ctrl #(
        .PROG_AW  (PROG_AW),
        .DATA_AW  (DATA_AW),
        .WR_DELAY (WR_DELAY)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_op   (done_op),
        .enabled    (prog_enabled),
        .busy       (busy),
        .prog_we    (prog_we),
        .data_we    (data_we),
        .erase_we   (erase_we),
        .erase_addr (erase_addr)
    );

    sp_mem #(
        .PROG_AW (PROG_AW),
        .DATA_AW (DATA_AW)
    ) u_mem (
        .clk        (clk),
        .prog_we    (prog_we),
        .prog_hi    (frame[27]),
        .prog_waddr (PROG_AW'(frame[23:8])),
        .prog_wdata (frame[7:0]),
        .data_we    (data_we),
        .data_waddr (DATA_AW'(frame[15:8])),
        .data_wdata (frame[7:0]),
        .erase_we   (erase_we),
        .erase_addr (erase_addr),
        .prog_raddr (PROG_AW'(frame[15:0])),
        .prog_rhi   (frame[19]),
        .prog_rdata (prog_rdata),
        .data_raddr (DATA_AW'(frame[7:0])),
        .data_rdata (data_rdata)
    );

    // Read-data selection for the fourth reply byte.
    always_comb begin
        rd_sel  = 1'b0;
        rd_byte = 8'h00;
        unique case (rd_op)
            OP_RD_PROG: begin
                rd_sel  = prog_enabled;
                rd_byte = prog_rdata;
            end
            OP_RD_DATA: begin
                rd_sel  = prog_enabled;
                rd_byte = data_rdata;
            end
            OP_RD_SIG: begin
                rd_sel = prog_enabled;
                unique case (frame[1:0])
                    2'd0:    rd_byte = SIG_VENDOR;
                    2'd1:    rd_byte = SIG_SIZE;
                    2'd2:    rd_byte = DEV_CODE;
                    default: rd_byte = BLANK;
                endcase
            end
            default: begin
                rd_sel  = 1'b0;
                rd_byte = 8'h00;
            end
        endcase
    end

endmodule

// File: rtl/sp_prog_chk.sv
module sp_prog_chk (
    input logic clk,
    input logic rst_n,
    input logic sck,
    input logic miso,
    input logic busy,
    input logic enabled,
    input logic frame_done,
    input logic prog_we,
    input logic data_we,
    input logic erase_we
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_we, data_we, erase_we})); // R9

    AST_WR_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_we || data_we) |-> frame_done); // R1

    AST_WR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_we || data_we) |-> !busy); // R9

    AST_WR_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_we || data_we) |=> busy); // R8

    AST_LOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |-> (!busy && !erase_we && !prog_we && !data_we)); // R3

    AST_MISO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck, 1) && $past(sck, 2) && $past(sck, 3) && $past(sck, 4) && $past(sck, 5))
        |-> $stable(miso)); // R2

endmodule

bind spi_prog_slave sp_prog_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck        (sck),
    .miso       (miso),
    .busy       (busy),
    .enabled    (prog_enabled),
    .frame_done (frame_done),
    .prog_we    (prog_we),
    .data_we    (data_we),
    .erase_we   (erase_we)
);

// File: tb/sim_spi_prog_slave.sv
module sim_spi_prog_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int WR_DLY     = 300;
    localparam int ERASE_RUN  = 512 + WR_DLY;
    localparam logic [7:0] DEV = 8'h05;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso, busy, prog_enabled;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state.
    logic [7:0] m_lo [512];
    logic [7:0] m_hi [512];
    logic [7:0] m_dat [64];
    logic [7:0] m_prev = 8'h00;
    bit         m_enabled = 0;
    int         exp_run = 0;
    int         run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_prog_slave #(
        .PROG_AW  (9),
        .DATA_AW  (6),
        .WR_DELAY (WR_DLY),
        .DEV_CODE (DEV)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .sck          (sck),
        .mosi         (mosi),
        .miso         (miso),
        .busy         (busy),
        .prog_enabled (prog_enabled)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Per-clock comparison of busy against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) begin
                run++;
                check(exp_run != 0, "R9", 1, 0);
            end else if (run != 0) begin
                check(run == exp_run, "R8", run, exp_run);
                run = 0;
                exp_run = 0;
            end
            if (!m_enabled)
                check(!busy, "R3", busy, 0);
        end
    end

    function automatic bit is_read(input logic [7:0] b0);
        return b0 == 8'h20 || b0 == 8'h28 || b0 == 8'hA0 || b0 == 8'h30;
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] b0, input logic [7:0] b1,
                                          input logic [7:0] b2);
        logic [8:0] wa;
        wa = {b1[0], b2};
        if (b0 == 8'h20) return m_lo[wa];
        if (b0 == 8'h28) return m_hi[wa];
        if (b0 == 8'hA0) return m_dat[b2[5:0]];
        case (b2[1:0])
            2'd0: return 8'h1E;
            2'd1: return 8'h90;
            2'd2: return DEV;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic apply_effect(input logic [7:0] b0, input logic [7:0] b1,
                                input logic [7:0] b2, input logic [7:0] b3);
        if (b0 == 8'hAC && b1 == 8'h53) begin
            m_enabled = 1;
        end else if (m_enabled && exp_run == 0) begin
            if (b0 == 8'hAC && b1[7:5] == 3'b100) begin
                for (int i = 0; i < 512; i++) begin m_lo[i] = 8'hFF; m_hi[i] = 8'hFF; end
                for (int i = 0; i < 64; i++) m_dat[i] = 8'hFF;
                exp_run = ERASE_RUN;
            end else if (b0 == 8'h40) begin
                m_lo[{b1[0], b2}] = b3; exp_run = WR_DLY;
            end else if (b0 == 8'h48) begin
                m_hi[{b1[0], b2}] = b3; exp_run = WR_DLY;
            end else if (b0 == 8'hC0) begin
                m_dat[b2[5:0]] = b3; exp_run = WR_DLY;
            end
        end
    endtask

    task automatic send(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                        input logic [7:0] b3, input string req);
        logic [7:0] tx [4];
        logic [7:0] ex [4];
        logic [7:0] got;
        tx[0] = b0; tx[1] = b1; tx[2] = b2; tx[3] = b3;
        ex[0] = m_prev; ex[1] = b0; ex[2] = b1;
        ex[3] = (m_enabled && is_read(b0)) ? m_read(b0, b1, b2) : b2;
        got = 8'h00;
        for (int k = 0; k < 4; k++) begin
            for (int i = 7; i >= 0; i--) begin
                mosi = tx[k][i];
                repeat (HALF) @(negedge clk);
                got[i] = miso;
                sck = 1'b1;
                if (k == 3 && i == 0) begin
                    m_prev = b3;
                    apply_effect(b0, b1, b2, b3);
                end
                repeat (HALF) @(negedge clk);
                sck = 1'b0;
            end
            check(got == ex[k], req, got, ex[k]);
        end
    endtask

    task automatic wait_idle();
        while (exp_run != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sck = 1'b0; mosi = 1'b0;
        repeat (5) @(negedge clk);
        m_prev = 8'h00; m_enabled = 0; exp_run = 0; run = 0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R11: reset state seen at the ports.
        check(miso == 1'b0, "R11", miso, 0);
        check(busy == 1'b0, "R11", busy, 0);
        check(prog_enabled == 1'b0, "R3", prog_enabled, 0);

        // R3: locked, reads echo and writes are dropped.
        send(8'h40, 8'h00, 8'h05, 8'h12, "R3");
        send(8'h20, 8'h00, 8'h05, 8'h00, "R3");
        send(8'hAC, 8'h80, 8'h00, 8'h00, "R3");
        repeat (20) @(negedge clk);
        check(prog_enabled == 1'b0, "R3", prog_enabled, 0);

        // R2 / R1: enable frame echoes 0x53 in byte 3; framing still aligned.
        send(8'hAC, 8'h53, 8'h00, 8'h00, "R2");
        repeat (4) @(negedge clk);
        check(prog_enabled == 1'b1, "R1", prog_enabled, 1);

        // R7: erase, then blank reads.
        send(8'hAC, 8'h80, 8'h00, 8'h00, "R7");
        wait_idle();
        send(8'h20, 8'h00, 8'h05, 8'h00, "R7");
        send(8'h28, 8'h01, 8'hFF, 8'h00, "R7");
        send(8'hA0, 8'h00, 8'h03, 8'h00, "R7");

        // R4: program memory lanes and top address.
        send(8'h40, 8'h00, 8'h05, 8'h12, "R4"); wait_idle();
        send(8'h48, 8'h00, 8'h05, 8'h34, "R4"); wait_idle();
        send(8'h40, 8'h01, 8'hFF, 8'hA5, "R4"); wait_idle();
        send(8'h20, 8'h00, 8'h05, 8'h00, "R4");
        send(8'h28, 8'h00, 8'h05, 8'h00, "R4");
        send(8'h20, 8'h01, 8'hFF, 8'h00, "R4");
        send(8'h28, 8'h01, 8'hFF, 8'h00, "R4");

        // R5: data memory, upper address bits ignored.
        send(8'hC0, 8'h00, 8'h3F, 8'h5A, "R5"); wait_idle();
        send(8'hC0, 8'h00, 8'h00, 8'hC3, "R5"); wait_idle();
        send(8'hA0, 8'h00, 8'h3F, 8'h00, "R5");
        send(8'hA0, 8'h00, 8'h40, 8'h00, "R5");

        // R6: identification bytes.
        for (int s = 0; s < 4; s++)
            send(8'h30, 8'h00, 8'(s), 8'h00, "R6");

        // R9: second write lands inside the busy window.
        send(8'h40, 8'h00, 8'h07, 8'h11, "R9");
        send(8'h40, 8'h00, 8'h07, 8'h22, "R9");
        wait_idle();
        send(8'h20, 8'h00, 8'h07, 8'h00, "R9");

        // R10: unknown opcode.
        send(8'h55, 8'h12, 8'h34, 8'h56, "R10");
        repeat (20) @(negedge clk);

        // R11: arrays survive reset; controller locks again.
        do_reset();
        check(prog_enabled == 1'b0, "R11", prog_enabled, 0);
        send(8'h40, 8'h00, 8'h05, 8'h99, "R3");
        send(8'h20, 8'h00, 8'h05, 8'h00, "R11");
        send(8'hAC, 8'h53, 8'h00, 8'h00, "R2");
        send(8'h20, 8'h00, 8'h05, 8'h00, "R11");
        send(8'hA0, 8'h00, 8'h3F, 8'h00, "R11");

        repeat (10) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule